// File: doc/BRIEF.md
# Priority Command Preemption Controller

This block sits beside the command queue of a memory controller and decides, once per clock, whether the entry waiting at the head of the queue may interrupt the command the core is executing. Both entries arrive as separate fields: a valid flag, a priority, a read/write flag, a port number, a source number, an address and a write-buffer slot. Two configuration bits set the policy. One enables preemption in general. The other allows a read to preempt a read from the same port.

When preemption is granted, the block raises a one-cycle pulse. In the same cycle it presents the head entry as the command to execute and the interrupted command as the one to put back in the queue. Both words are registered and hold their value until the next grant. After a grant, the cycle that follows is a hold-off cycle, so the new active command is held for at least one cycle before it can be judged again. Queue storage, command placement, priority aging and DRAM timing are handled elsewhere.

Top module: `prio_preempt_ctrl`

## Requirements
- R1: While `cfg_swap_en` is 0, `preempt_pulse` stays 0 whatever the two entries hold.
- R2: A grant needs the head priority to be numerically smaller than the active priority, where 0 is the most urgent value. An equal or larger head priority never produces a grant, even when there is no conflict and the ports differ.
- R3: A grant is blocked when the row-and-bank parts of the two addresses are equal. That part is the address bits above the lowest `COL_W` bits, with `COL_W` = 6 by default. Addresses that differ only in their lowest `COL_W` bits therefore block a grant, and addresses whose upper bits differ do not.
- R4: A grant is blocked when the two source numbers are equal.
- R5: A grant is blocked when both commands are writes and their write-buffer slots are equal. A read paired with a write that uses the same slot number is not blocked by the slot.
- R6: When both commands are reads from the same port, a grant also needs `cfg_rd_same_port_en` = 1.
- R7: Two writes from the same port never produce a grant, whatever either configuration bit holds. A read and a write from the same port may produce a grant.
- R8: When `head_vld` or `act_vld` is 0, `preempt_pulse` stays 0.
- R9: The decision is registered. Inputs that qualify at a rising edge give `preempt_pulse` = 1 for exactly the following cycle.
- R10: In the cycle after a pulse no grant is made, even if the inputs still qualify. Qualifying inputs that are still held in the cycle after that produce a new grant.
- R11: On a grant, `exec_cmd` takes the head entry and `requeue_cmd` takes the active entry. Both are packed with priority in bits [29:26], write flag in bit 25, port in bits [24:23], source in bits [22:19], address in bits [18:3] and write-buffer slot in bits [2:0]. Both words hold their value between grants.
- R12: A synchronous active-high `rst` clears `preempt_pulse`, `exec_cmd` and `requeue_cmd` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_swap_en | input | 1 | Enables preemption in general |
| cfg_rd_same_port_en | input | 1 | Allows a read to preempt a read from the same port |
| head_vld | input | 1 | The head entry is present |
| head_prio | input | 4 | Head priority, 0 is most urgent |
| head_wr | input | 1 | Head is a write (1) or a read (0) |
| head_port | input | 2 | Head originating port |
| head_src | input | 4 | Head source number |
| head_addr | input | 16 | Head address |
| head_wbuf | input | 3 | Head write-buffer slot |
| act_vld | input | 1 | An active command is executing |
| act_prio | input | 4 | Active priority |
| act_wr | input | 1 | Active is a write (1) or a read (0) |
| act_port | input | 2 | Active originating port |
| act_src | input | 4 | Active source number |
| act_addr | input | 16 | Active address |
| act_wbuf | input | 3 | Active write-buffer slot |
| preempt_pulse | output | 1 | One-cycle grant pulse |
| exec_cmd | output | 30 | Command to execute after the latest grant |
| requeue_cmd | output | 30 | Interrupted command to return to the queue |

## Verification
The assertions assume that the entry and configuration inputs are stable around each rising edge. They also assume that the two words are meaningful only while their valid flags are set, which is why every rule that concerns the fields is qualified by both valid flags or by the grant itself. The bench changes inputs only one time unit after a falling edge, so they never move near the sampling edge. Random stimulus draws ports, sources and slots from small ranges and addresses from only a few rows, so that conflicts, same-port pairs and priority ties come up often while every value stays legal.

// File: rtl/pp_pkg.sv
package pp_pkg;
    localparam int PRIO_W = 4;
    localparam int PORT_W = 2;
    localparam int SRC_W  = 4;
    localparam int ADDR_W = 16;
    localparam int WBUF_W = 3;
    localparam int CMD_W  = PRIO_W + 1 + PORT_W + SRC_W + ADDR_W + WBUF_W;

    // Packed most significant field first; this layout is visible at the ports.
    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic              wr;
        logic [PORT_W-1:0] port;
        logic [SRC_W-1:0]  src;
        logic [ADDR_W-1:0] addr;
        logic [WBUF_W-1:0] wbuf;
    } cmd_t;

    // Smaller number means more urgent.
    function automatic logic more_urgent(input logic [PRIO_W-1:0] a,
                                         input logic [PRIO_W-1:0] b);
        return a < b;
    endfunction
endpackage

// File: rtl/pp_conflict.sv
module pp_conflict
    import pp_pkg::*;
#(
    parameter int COL_W = 6
) (
    input  cmd_t a,
    input  cmd_t b,
    output logic hit
);
    logic row_hit, src_hit, wbuf_hit;

    generate
        if (COL_W > 0) begin : g_row
            assign row_hit = (a.addr[ADDR_W-1:COL_W] == b.addr[ADDR_W-1:COL_W]);
        end else begin : g_full
            assign row_hit = (a.addr == b.addr);
        end
    endgenerate

    assign src_hit  = (a.src == b.src);
    assign wbuf_hit = a.wr && b.wr && (a.wbuf == b.wbuf);
    assign hit      = row_hit || src_hit || wbuf_hit;
endmodule

// File: rtl/pp_policy.sv
module pp_policy
    import pp_pkg::*;
(
    input  cmd_t head,
    input  cmd_t act,
    input  logic head_vld,
    input  logic act_vld,
    input  logic swap_en,
    input  logic rd_same_en,
    input  logic conflict,
    input  logic holdoff,
    output logic allow
);
    logic same_port, rd_rd_block, wr_wr_block;

    assign same_port   = (head.port == act.port);
    assign rd_rd_block = same_port && !head.wr && !act.wr && !rd_same_en;
    assign wr_wr_block = same_port && head.wr && act.wr;

    always_comb begin
        allow = swap_en && head_vld && act_vld && !holdoff
             && more_urgent(head.prio, act.prio)
             && !conflict && !rd_rd_block && !wr_wr_block;
    end
endmodule

// File: rtl/prio_preempt_ctrl.sv
module prio_preempt_ctrl
    import pp_pkg::*;
#(
    parameter int COL_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_swap_en,
    input  logic              cfg_rd_same_port_en,
    input  logic              head_vld,
    input  logic [PRIO_W-1:0] head_prio,
    input  logic              head_wr,
    input  logic [PORT_W-1:0] head_port,
    input  logic [SRC_W-1:0]  head_src,
    input  logic [ADDR_W-1:0] head_addr,
    input  logic [WBUF_W-1:0] head_wbuf,
    input  logic              act_vld,
    input  logic [PRIO_W-1:0] act_prio,
    input  logic              act_wr,
    input  logic [PORT_W-1:0] act_port,
    input  logic [SRC_W-1:0]  act_src,
    input  logic [ADDR_W-1:0] act_addr,
    input  logic [WBUF_W-1:0] act_wbuf,
    output logic              preempt_pulse,
    output logic [CMD_W-1:0]  exec_cmd,
    output logic [CMD_W-1:0]  requeue_cmd
);
    cmd_t head_c, act_c, exec_q, requeue_q;
    logic conflict, allow, pulse_q;

    assign head_c = '{prio: head_prio, wr: head_wr, port: head_port,
                      src: head_src, addr: head_addr, wbuf: head_wbuf};
    assign act_c  = '{prio: act_prio, wr: act_wr, port: act_port,
                      src: act_src, addr: act_addr, wbuf: act_wbuf};

    pp_conflict #(.COL_W(COL_W)) u_conflict (
        .a   (head_c),
        .b   (act_c),
        .hit (conflict)
    );

    // The pulse register also serves as the one-cycle hold-off.
    pp_policy u_policy (
        .head       (head_c),
        .act        (act_c),
        .head_vld   (head_vld),
        .act_vld    (act_vld),
        .swap_en    (cfg_swap_en),
        .rd_same_en (cfg_rd_same_port_en),
        .conflict   (conflict),
        .holdoff    (pulse_q),
        .allow      (allow)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q   <= 1'b0;
            exec_q    <= '0;
            requeue_q <= '0;
        end else begin
            pulse_q <= allow;
            if (allow) begin
                exec_q    <= head_c;
                requeue_q <= act_c;
            end
        end
    end

    assign preempt_pulse = pulse_q;
    assign exec_cmd      = exec_q;
    assign requeue_cmd   = requeue_q;

    // R1
    swap_off_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_swap_en |=> !preempt_pulse);

    // R2
    prio_strict_chk: assert property (@(posedge clk) disable iff (rst)
        (head_prio >= act_prio) |=> !preempt_pulse);

    // R7
    wr_order_chk: assert property (@(posedge clk) disable iff (rst)
        (head_wr && act_wr && head_port == act_port) |=> !preempt_pulse);

    // R8
    valid_chk: assert property (@(posedge clk) disable iff (rst)
        (!head_vld || !act_vld) |=> !preempt_pulse);

    // R10
    holdoff_chk: assert property (@(posedge clk) disable iff (rst)
        preempt_pulse |=> !preempt_pulse);

    // R11
    swap_order_chk: assert property (@(posedge clk) disable iff (rst)
        preempt_pulse |-> (exec_q.prio < requeue_q.prio));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !preempt_pulse |=> preempt_pulse || ($stable(exec_cmd) && $stable(requeue_cmd)));
endmodule

// File: tb/tb_prio_preempt_ctrl.sv
module tb_prio_preempt_ctrl;
    import pp_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_swap_en = 1'b0, cfg_rd_same_port_en = 1'b0;
    logic head_vld = 1'b0, act_vld = 1'b0;
    cmd_t h_s = '0, a_s = '0;
    logic preempt_pulse;
    logic [CMD_W-1:0] exec_cmd, requeue_cmd;

    always #2.5 clk = ~clk;

    prio_preempt_ctrl dut (
        .clk(clk), .rst(rst),
        .cfg_swap_en(cfg_swap_en), .cfg_rd_same_port_en(cfg_rd_same_port_en),
        .head_vld(head_vld), .head_prio(h_s.prio), .head_wr(h_s.wr),
        .head_port(h_s.port), .head_src(h_s.src), .head_addr(h_s.addr),
        .head_wbuf(h_s.wbuf),
        .act_vld(act_vld), .act_prio(a_s.prio), .act_wr(a_s.wr),
        .act_port(a_s.port), .act_src(a_s.src), .act_addr(a_s.addr),
        .act_wbuf(a_s.wbuf),
        .preempt_pulse(preempt_pulse), .exec_cmd(exec_cmd), .requeue_cmd(requeue_cmd)
    );

    int checks = 0, errors = 0;
    bit done = 0;
    logic             q_irq[$];
    logic [CMD_W-1:0] q_ex[$];
    logic [CMD_W-1:0] q_rq[$];
    string            q_tag[$];

    // Scoreboard model state
    logic             m_irq = 1'b0;
    logic [CMD_W-1:0] m_ex = '0, m_rq = '0;

    function automatic logic qualifies(cmd_t h, cmd_t a, logic hv, logic av,
                                       logic en, logic rden);
        logic ok;
        ok = en && hv && av && (h.prio < a.prio);
        if (h.addr[15:6] == a.addr[15:6]) ok = 0;            // R3
        if (h.src == a.src) ok = 0;                          // R4
        if (h.wr && a.wr && h.wbuf == a.wbuf) ok = 0;        // R5
        if (!h.wr && !a.wr && h.port == a.port && !rden) ok = 0; // R6
        if (h.wr && a.wr && h.port == a.port) ok = 0;        // R7
        return ok;
    endfunction

    function automatic cmd_t mk(int pr, bit wr, int pt, int sr, int ad, int wb);
        cmd_t c;
        c.prio = 4'(pr); c.wr = wr; c.port = 2'(pt);
        c.src = 4'(sr); c.addr = 16'(ad); c.wbuf = 3'(wb);
        return c;
    endfunction

    task automatic apply(cmd_t h, cmd_t a, logic hv, logic av,
                         logic en, logic rden, string tag);
        logic g;
        @(negedge clk);
        #1;
        h_s = h; a_s = a; head_vld = hv; act_vld = av;
        cfg_swap_en = en; cfg_rd_same_port_en = rden;
        g = qualifies(h, a, hv, av, en, rden) && !m_irq;    // R10 hold-off
        if (g) begin
            m_ex = h;
            m_rq = a;
        end
        m_irq = g;
        q_irq.push_back(g); q_ex.push_back(m_ex); q_rq.push_back(m_rq);
        q_tag.push_back(tag);
    endtask

    task automatic idle();
        apply('0, '0, 0, 0, 0, 0, "R8 idle");
    endtask

    // Monitor: compares what was driven one cycle earlier
    always @(negedge clk) begin
        if (!done && q_irq.size() > 0) begin
            logic ei;
            logic [CMD_W-1:0] ee, er;
            string t;
            bit bad;
            ei = q_irq.pop_front(); ee = q_ex.pop_front();
            er = q_rq.pop_front(); t = q_tag.pop_front();
            checks++;
            bad = 0;
            if (preempt_pulse !== ei) begin
                $display("FAIL %s pulse: actual %0b expected %0b", t, preempt_pulse, ei);
                bad = 1;
            end
            if (exec_cmd !== ee) begin
                $display("FAIL %s R11 exec_cmd: actual %h expected %h", t, exec_cmd, ee);
                bad = 1;
            end
            if (requeue_cmd !== er) begin
                $display("FAIL %s R11 requeue_cmd: actual %h expected %h", t, requeue_cmd, er);
                bad = 1;
            end
            if (bad) errors++;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cmd_t hh, aa;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        // R12 reset state
        if (preempt_pulse !== 1'b0 || exec_cmd !== '0 || requeue_cmd !== '0) begin
            errors++;
            $display("FAIL R12 reset: actual %0b/%h/%h expected 0/0/0",
                     preempt_pulse, exec_cmd, requeue_cmd);
        end
        rst = 1'b0;

        // Base pair: different ports, sources, rows, slots; head more urgent.
        hh = mk(1, 0, 0, 1, 16'h0100, 1);
        aa = mk(5, 1, 1, 2, 16'h0200, 2);

        apply(hh, aa, 1, 1, 0, 1, "R1 swap disabled");           idle();
        apply(hh, aa, 1, 1, 1, 0, "R2 basic grant");             idle();
        apply(mk(5,0,0,1,16'h0100,1), aa, 1, 1, 1, 1, "R2 equal priority"); idle();
        apply(mk(9,0,0,1,16'h0100,1), aa, 1, 1, 1, 1, "R2 head less urgent"); idle();
        apply(mk(9,0,0,2,16'h0200,2), aa, 1, 1, 1, 1, "R2 less urgent with conflict"); idle();
        apply(mk(1,0,0,1,16'h0205,1), aa, 1, 1, 1, 1, "R3 row match, column differs"); idle();
        apply(mk(1,0,0,1,16'h0240,1), aa, 1, 1, 1, 1, "R3 row differs"); idle();
        apply(mk(1,0,0,2,16'h0100,1), aa, 1, 1, 1, 1, "R4 source match"); idle();
        apply(mk(1,1,0,1,16'h0100,2), aa, 1, 1, 1, 1, "R5 write slot match"); idle();
        apply(mk(1,0,0,1,16'h0100,2), aa, 1, 1, 1, 1, "R5 read vs write same slot"); idle();
        apply(mk(1,0,3,1,16'h0100,1), mk(6,0,3,4,16'h0800,1), 1, 1, 1, 0, "R6 same-port reads off"); idle();
        apply(mk(1,0,3,1,16'h0100,1), mk(6,0,3,4,16'h0800,1), 1, 1, 1, 1, "R6 same-port reads on"); idle();
        apply(mk(1,1,2,1,16'h0100,1), mk(6,1,2,4,16'h0800,5), 1, 1, 1, 1, "R7 same-port writes"); idle();
        apply(mk(1,1,2,1,16'h0100,1), mk(6,0,2,4,16'h0800,5), 1, 1, 1, 0, "R7 same-port write over read"); idle();
        apply(hh, aa, 0, 1, 1, 1, "R8 head invalid");            idle();
        apply(hh, aa, 1, 0, 1, 1, "R8 active invalid");          idle();
        apply(hh, aa, 1, 1, 1, 1, "R9 pulse cycle");
        apply(hh, aa, 1, 1, 1, 1, "R10 hold-off cycle");
        apply(hh, aa, 1, 1, 1, 1, "R10 grant after hold-off");
        idle(); idle();

        for (int i = 0; i < 400; i++) begin
            hh = mk($urandom % 16, 1'($urandom), $urandom % 2, $urandom % 4,
                    (($urandom % 3) << 6) | ($urandom % 64), $urandom % 3);
            aa = mk($urandom % 16, 1'($urandom), $urandom % 2, $urandom % 4,
                    (($urandom % 3) << 6) | ($urandom % 64), $urandom % 3);
            apply(hh, aa, ($urandom % 8) != 0, ($urandom % 8) != 0,
                  ($urandom % 6) != 0, 1'($urandom), "R11 random mix");
        end
        idle();
        @(negedge clk); @(negedge clk);
        if (!done) begin
            done = 1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule